// File: doc/BRIEF.md
# Indexed Address Generator with Space Select

This block keeps a 12-bit index register and turns it, together with an 8-bit offset taken from an instruction, into the effective address of an indexed load or store. The top bit of the index steers the access. When it is clear, the access lands in a 256-byte data window at the bottom of the address map. When it is set, the access lands in the upper half of the map, which holds program storage and can only be read. Alongside the address the block drives a space-select flag and a write-permit signal. The write-permit signal lets a store go ahead only when the access targets the data window.

Software reaches the register in three ways. A dedicated load path writes all twelve bits in one cycle. Two memory-mapped byte locations give access to the register in halves: 0xBE holds the upper nibble and 0xBF holds the lower byte. Increment and decrement strobes let the eleven address bits act as a counter. The space-select bit can be written but never reads back, so software sees only the eleven address bits. Instruction decode, the memories and the arithmetic unit are outside this block.

Top module: `idx_agen`

## Requirements
- R1: After reset the index register is 0x000. So `ea` equals `{4'h0, offset}`, `prog_sel` is 0, and reads of 0xBE and 0xBF both return 0x00.
- R2: With `ld_full` high, the register takes all 12 bits of `ld_value` at the next clock edge. This load wins over a byte write and over counting in the same cycle.
- R3: A byte write (`mm_wr` high) to address 0xBE loads register bits [11:8] from `mm_wdata[3:0]`. A byte write to 0xBF loads bits [7:0] from `mm_wdata[7:0]`. A byte write to any other address leaves the register unchanged.
- R4: Reads are combinational. At 0xBE `mm_rdata` is `{5'b0, X[10:8]}`, so bit 11 always reads as 0. At 0xBF `mm_rdata` is `X[7:0]`. `mm_hit` is 1 for these two addresses only. Any other address gives 0x00 with `mm_hit` at 0.
- R5: When bit 11 is 0, `prog_sel` is 0 and `ea` is `{4'h0, (X[7:0] + offset) mod 256}`. The sum wraps inside the data window.
- R6: When bit 11 is 1, `prog_sel` is 1 and `ea` is `{1'b1, (X[10:0] + offset) mod 2048}`. The sum wraps inside the program window.
- R7: `wr_permit` equals `store_req` while bit 11 is 0. It is held at 0 while bit 11 is 1.
- R8: `cnt_inc` alone adds 1 to bits [10:0] modulo 2048. `cnt_dec` alone subtracts 1 from bits [10:0] modulo 2048. Neither changes bit 11. With both high or both low, the register holds. A full load or a byte write to 0xBE or 0xBF in the same cycle takes priority over counting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_full | input | 1 | Load all index bits from `ld_value` |
| ld_value | input | 12 | Full-width load value |
| mm_wr | input | 1 | Memory-mapped byte write strobe |
| mm_addr | input | 8 | Memory-mapped byte address, for both reads and writes |
| mm_wdata | input | 8 | Memory-mapped write data |
| mm_rdata | output | 8 | Memory-mapped read data |
| mm_hit | output | 1 | `mm_addr` selects one of the index bytes |
| cnt_inc | input | 1 | Increment the index address bits |
| cnt_dec | input | 1 | Decrement the index address bits |
| offset | input | 8 | Instruction offset added to the index |
| store_req | input | 1 | The current indexed access is a store |
| ea | output | 12 | Effective address |
| prog_sel | output | 1 | 1 = program space, 0 = data space |
| wr_permit | output | 1 | The store may proceed |

## Verification
The bench aims at the two wrap boundaries. A data-space sum that carries past bit 7 must stay in the window; a design that lets the carry through would address 0x100 and above, outside the data window. A program-space sum past 0x7FF must wrap to 0x800; a carry leaking into bit 11 would flip the space flag.

Counting is tested across 0x7FF↔0x000 with bit 11 in both states. A counter spanning all twelve bits would change the space select when it wraps.

Readback of 0xBE is tested with bit 11 set, so a design that exposes the write-only bit shows up there. A store into program space must keep `wr_permit` low, or the program storage would be corrupted. The bench also checks the priority order in same-cycle conflicts, and that writes to neighbouring addresses are ignored.

// File: rtl/idx_agen.sv
module idx_agen #(
  parameter int IDX_W   = 12,
  parameter int OFS_W   = 8,
  parameter logic [7:0] HI_ADDR = 8'hBE,
  parameter logic [7:0] LO_ADDR = 8'hBF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_full,
  input  logic [IDX_W-1:0] ld_value,
  input  logic             mm_wr,
  input  logic [7:0]       mm_addr,
  input  logic [7:0]       mm_wdata,
  output logic [7:0]       mm_rdata,
  output logic             mm_hit,
  input  logic             cnt_inc,
  input  logic             cnt_dec,
  input  logic [OFS_W-1:0] offset,
  input  logic             store_req,
  output logic [IDX_W-1:0] ea,
  output logic             prog_sel,
  output logic             wr_permit
);
  localparam int LOW_W = IDX_W - 1;
  localparam int HI_W  = IDX_W - 8;
  localparam int PAD_W = IDX_W - 8;

  logic [IDX_W-1:0] x_q, x_d;
  logic             hi_sel, lo_sel;
  logic [7:0]       data_sum;
  logic [LOW_W-1:0] prog_sum;

  assign hi_sel = (mm_addr == HI_ADDR);
  assign lo_sel = (mm_addr == LO_ADDR);

  always_comb begin
    x_d = x_q;
    if (ld_full)
      x_d = ld_value;
    else if (mm_wr && hi_sel)
      x_d[IDX_W-1:8] = mm_wdata[HI_W-1:0];
    else if (mm_wr && lo_sel)
      x_d[7:0] = mm_wdata;
    else if (cnt_inc && !cnt_dec)
      x_d[LOW_W-1:0] = x_q[LOW_W-1:0] + LOW_W'(1);
    else if (cnt_dec && !cnt_inc)
      x_d[LOW_W-1:0] = x_q[LOW_W-1:0] - LOW_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) x_q <= '0;
    else        x_q <= x_d;
  end

  assign mm_hit   = hi_sel | lo_sel;
  assign mm_rdata = hi_sel ? 8'(x_q[LOW_W-1:8]) :
                    lo_sel ? x_q[7:0] : 8'h00;

  assign prog_sel  = x_q[IDX_W-1];
  assign data_sum  = x_q[7:0] + 8'(offset);
  assign prog_sum  = x_q[LOW_W-1:0] + LOW_W'(offset);
  assign ea        = prog_sel ? {1'b1, prog_sum} : {{PAD_W{1'b0}}, data_sum};
  assign wr_permit = store_req & ~prog_sel;
endmodule

// File: rtl/idx_agen_chk.sv
module idx_agen_chk #(
  parameter int IDX_W = 12,
  parameter int OFS_W = 8,
  parameter logic [7:0] HI_ADDR = 8'hBE,
  parameter logic [7:0] LO_ADDR = 8'hBF
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ld_full,
  input logic [IDX_W-1:0] ld_value,
  input logic             mm_wr,
  input logic [7:0]       mm_addr,
  input logic [7:0]       mm_rdata,
  input logic             cnt_inc,
  input logic             cnt_dec,
  input logic             store_req,
  input logic [IDX_W-1:0] ea,
  input logic             prog_sel,
  input logic             wr_permit,
  input logic [IDX_W-1:0] x_q
);
  logic quiet;
  assign quiet = !ld_full && !(mm_wr && (mm_addr == HI_ADDR || mm_addr == LO_ADDR));

  // R2
  full_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_full |=> x_q == $past(ld_value));

  // R8
  inc_low_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && cnt_inc && !cnt_dec) |=>
      (x_q[IDX_W-2:0] == $past(x_q[IDX_W-2:0]) + 1'b1) && $stable(x_q[IDX_W-1]));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && (cnt_inc == cnt_dec)) |=> $stable(x_q));

  // R7
  no_prog_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_sel |-> !wr_permit);

  // R4
  hi_read_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mm_addr == HI_ADDR) |-> mm_rdata[7:3] == 5'd0);

  // R5
  data_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_sel |-> ea[IDX_W-1:8] == '0);

  // R6
  prog_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_sel |-> ea[IDX_W-1]);

  // R7
  data_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!prog_sel && store_req) |-> wr_permit);
endmodule

bind idx_agen idx_agen_chk #(.IDX_W(IDX_W), .OFS_W(OFS_W), .HI_ADDR(HI_ADDR), .LO_ADDR(LO_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .ld_full(ld_full), .ld_value(ld_value),
  .mm_wr(mm_wr), .mm_addr(mm_addr), .mm_rdata(mm_rdata),
  .cnt_inc(cnt_inc), .cnt_dec(cnt_dec), .store_req(store_req),
  .ea(ea), .prog_sel(prog_sel), .wr_permit(wr_permit), .x_q(x_q)
);

// File: tb/idx_agen_tb.sv
module idx_agen_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        ld_full = 0, mm_wr = 0, cnt_inc = 0, cnt_dec = 0, store_req = 0;
  logic [11:0] ld_value = '0;
  logic [7:0]  mm_addr = '0, mm_wdata = '0, offset = '0;
  logic [7:0]  mm_rdata;
  logic        mm_hit, prog_sel, wr_permit;
  logic [11:0] ea;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  idx_agen u_dut (
    .clk(clk), .rst_n(rst_n), .ld_full(ld_full), .ld_value(ld_value),
    .mm_wr(mm_wr), .mm_addr(mm_addr), .mm_wdata(mm_wdata), .mm_rdata(mm_rdata),
    .mm_hit(mm_hit), .cnt_inc(cnt_inc), .cnt_dec(cnt_dec), .offset(offset),
    .store_req(store_req), .ea(ea), .prog_sel(prog_sel), .wr_permit(wr_permit)
  );

  task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%03h expected 0x%03h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
    ld_full = 0; mm_wr = 0; cnt_inc = 0; cnt_dec = 0;
  endtask

  task automatic load(input logic [11:0] v);
    ld_full = 1; ld_value = v; step();
  endtask

  task automatic bwrite(input logic [7:0] a, input logic [7:0] d);
    mm_wr = 1; mm_addr = a; mm_wdata = d; step();
  endtask

  task automatic rd(input logic [7:0] a, input string tag, input logic [7:0] exp, input logic exp_hit);
    mm_addr = a; #1;
    chk(tag, {4'h0, mm_rdata}, {4'h0, exp});
    chk({tag, " hit"}, {11'h0, mm_hit}, {11'h0, exp_hit});
  endtask

  task automatic t_reset();
    offset = 8'h37; #1;
    chk("R1 ea", ea, 12'h037);
    chk("R1 prog_sel", {11'h0, prog_sel}, 12'h0);
    rd(8'hBE, "R1 rd hi", 8'h00, 1);
    rd(8'hBF, "R1 rd lo", 8'h00, 1);
  endtask

  task automatic t_full_load();
    load(12'hA5C);
    offset = 8'h00; #1;
    chk("R2 full load ea", ea, 12'hA5C);
    ld_full = 1; ld_value = 12'h123; mm_wr = 1; mm_addr = 8'hBF; mm_wdata = 8'hEE; cnt_inc = 1;
    step();
    chk("R2 priority", ea, 12'h023);
    rd(8'hBF, "R2 priority lo", 8'h23, 1);
    rd(8'hBE, "R2 priority hi", 8'h01, 1);
  endtask

  task automatic t_bytes();
    load(12'h000);
    bwrite(8'hBE, 8'hFA);
    bwrite(8'hBF, 8'h33);
    offset = 8'h00; #1;
    chk("R3 byte writes", ea, 12'hA33);
    chk("R3 bit11 set", {11'h0, prog_sel}, 12'h1);
    bwrite(8'hC0, 8'h55);
    bwrite(8'hBD, 8'h00);
    offset = 8'h00; #1;
    chk("R3 other addr ignored", ea, 12'hA33);
    rd(8'hBE, "R4 hi masks bit11", 8'h02, 1);
    rd(8'hBF, "R4 lo", 8'h33, 1);
    rd(8'h40, "R4 unmapped", 8'h00, 0);
  endtask

  task automatic t_data_space();
    load(12'h0F0);
    offset = 8'h05; #1;
    chk("R5 plain", ea, 12'h0F5);
    offset = 8'h20; #1;
    chk("R5 wrap in window", ea, 12'h010);
    chk("R5 prog_sel", {11'h0, prog_sel}, 12'h0);
    load(12'h3F0);
    offset = 8'h20; #1;
    chk("R5 upper bits dropped", ea, 12'h010);
  endtask

  task automatic t_prog_space();
    load(12'hA5C);
    offset = 8'h10; #1;
    chk("R6 plain", ea, 12'hA6C);
    load(12'hFFF);
    offset = 8'h01; #1;
    chk("R6 wrap in window", ea, 12'h800);
    chk("R6 prog_sel", {11'h0, prog_sel}, 12'h1);
  endtask

  task automatic t_store();
    load(12'h010);
    store_req = 1; #1;
    chk("R7 data store", {11'h0, wr_permit}, 12'h1);
    store_req = 0; #1;
    chk("R7 no request", {11'h0, wr_permit}, 12'h0);
    load(12'h810);
    store_req = 1; #1;
    chk("R7 prog store blocked", {11'h0, wr_permit}, 12'h0);
    store_req = 0;
  endtask

  task automatic t_count();
    offset = 8'h00;
    load(12'h7FF);
    cnt_inc = 1; step();
    chk("R8 inc wrap keeps bit11 0", ea, 12'h000);
    chk("R8 inc prog_sel", {11'h0, prog_sel}, 12'h0);
    load(12'h800);
    cnt_dec = 1; step();
    chk("R8 dec wrap keeps bit11 1", {11'h0, prog_sel}, 12'h1);
    rd(8'hBE, "R8 dec hi", 8'h07, 1);
    rd(8'hBF, "R8 dec lo", 8'hFF, 1);
    load(12'h345);
    cnt_inc = 1; cnt_dec = 1; step();
    chk("R8 both hold", ea, {4'h0, 8'h45});
    rd(8'hBF, "R8 both hold lo", 8'h45, 1);
    mm_wr = 1; mm_addr = 8'hBF; mm_wdata = 8'h80; cnt_inc = 1; step();
    rd(8'hBF, "R8 byte write wins", 8'h80, 1);
    load(12'h0FF);
    cnt_inc = 1; step();
    rd(8'hBE, "R8 carry into hi", 8'h01, 1);
    rd(8'hBF, "R8 carry lo", 8'h00, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_full_load();
    t_bytes();
    t_data_space();
    t_prog_space();
    t_store();
    t_count();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule